// File: doc/BRIEF.md
# MDIO Clause-22 Management Master

This block runs Clause-22 management frames to an external PHY. It produces the management clock (`mdc`) and drives the data line through an output value, an output enable and a sampled input. The three pins together make a bidirectional line with a pull-up. A command port takes an operation (read or write), a 5-bit PHY address, a 5-bit register address and 16 bits of write data. When the frame ends, the block returns 16 bits of read data, a flag that says whether the PHY answered, and a single-cycle done pulse.

Every frame is 65 MDC cycles long. The order is: 32 released preamble cycles, 4 start/opcode bits, 5 PHY-address bits, 5 register-address bits, 2 turnaround cycles, 16 data bits, then one released idle cycle. The MDC half-period is a number of system clocks taken from an input divisor. A manual mode lets software drive the clock, data and enable pins directly and read back the pin level. Entering manual mode stops the automatic sequencer.

Top module: `mdio_c22_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are all low.
- R2: During MDC cycles 0..31 of a frame (the preamble), `mdio_oe` is low.
- R3: In MDC cycles 32..35 the driver is enabled and sends 0,1,1,0 for a read (`cmd_write`=0) or 0,1,0,1 for a write (`cmd_write`=1).
- R4: In cycles 36..40 the driver sends the PHY address, MSB first. In cycles 41..45 it sends the register address, MSB first.
- R5: For a read, the driver is released from cycle 46 through cycle 64. The line is sampled on the MDC rising edge of cycle 47 as the acknowledge, where low means the PHY answered. The data bits are sampled on the rising edges of cycles 48..63, MSB first. An answered read gives `ack_ok`=1 and those 16 bits on `rd_data`.
- R6: If the acknowledge sample is high, the block still runs all 65 MDC cycles, and it returns `rd_data`=16'hFFFF with `ack_ok`=0.
- R7: For a write, the driver sends 1 in cycle 46 and 0 in cycle 47. It then sends the 16 data bits, MSB first, in cycles 48..63.
- R8: In cycle 64 the driver is released. A frame has exactly 65 MDC rising edges, and `done` rises on the system edge where the last MDC high phase ends.
- R9: Each MDC high and low phase lasts `div_half` system clocks. A divisor of 0 counts as 1. The driven data changes only when MDC falls.
- R10: A command is accepted only while the block is idle and not in manual mode. `busy` is high for the whole frame. `done` is a one-clock pulse on the edge where `busy` falls, with `rd_data` and `ack_ok` valid from that edge. A command presented while busy is ignored.
- R11: While `man_en` is high, `mdc` follows `man_ctrl[2]`, `mdio_oe` follows `man_ctrl[1]` and `mdio_o` follows `man_ctrl[0]`. `man_pin` returns the level of `mdio_i` one system clock later.
- R12: Raising `man_en` aborts any running frame without a `done` pulse. While `man_en` is high, commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_half | input | 16 | MDC half-period in system clocks (0 is treated as 1) |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_write | input | 1 | 1 = write frame, 0 = read frame |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rd_data | output | 16 | Read result (16'hFFFF when not acknowledged) |
| ack_ok | output | 1 | PHY acknowledged the last read |
| man_en | input | 1 | Manual pin-control mode |
| man_ctrl | input | 3 | Manual bits: [0] data, [1] enable, [2] clock |
| man_pin | output | 1 | Registered data-pin level |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled level |

## Verification
If the frame-cycle counter goes wrong, the error shows at the pins within one MDC cycle. The driver enables at the wrong place, or a header bit shifts, and the frame no longer has exactly 65 rising edges before `done`. If the acknowledge or shift register goes wrong, only `rd_data` and `ack_ok` show it, and only at the `done` edge. This is why every read case compares the full word there. A wrong divider count or wrong phase shows up within one half-period as an MDC high time that differs from `div_half`.

// File: rtl/mdio_c22_pkg.sv
package mdio_c22_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int CYC_W  = 7;
  typedef logic [CYC_W-1:0] cyc_t;

  // Slot boundaries inside a 65-cycle frame
  localparam cyc_t HDR_FIRST  = 7'd32;
  localparam cyc_t PHY_FIRST  = 7'd36;
  localparam cyc_t REG_FIRST  = 7'd41;
  localparam cyc_t TA_FIRST   = 7'd46;
  localparam cyc_t ACK_SLOT   = 7'd47;
  localparam cyc_t DATA_FIRST = 7'd48;
  localparam cyc_t LAST_SLOT  = 7'd64;

  // Effective half-period: zero is promoted to one
  function automatic logic [15:0] half_len(input logic [15:0] d);
    return (d == 16'd0) ? 16'd1 : d;
  endfunction

  // Returns {enable, value} for frame slot c
  function automatic logic [1:0] drive_slot(input cyc_t c, input logic wr,
                                            input logic [ADDR_W-1:0] phy,
                                            input logic [ADDR_W-1:0] rga,
                                            input logic [DATA_W-1:0] wd);
    logic [3:0] hdr;
    int i;
    hdr = wr ? 4'b0101 : 4'b0110;
    i = int'(c);
    if (c < HDR_FIRST)       return 2'b00;
    else if (c < PHY_FIRST)  return {1'b1, hdr[35-i]};
    else if (c < REG_FIRST)  return {1'b1, phy[40-i]};
    else if (c < TA_FIRST)   return {1'b1, rga[45-i]};
    else if (c < DATA_FIRST) return wr ? {1'b1, (c == TA_FIRST)} : 2'b00;
    else if (c < LAST_SLOT)  return wr ? {1'b1, wd[63-i]} : 2'b00;
    else                     return 2'b00;
  endfunction
endpackage

// File: rtl/mdio_c22_divider.sv
module mdio_c22_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             tick
);
  import mdio_c22_pkg::*;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] eff;

  assign eff  = half_len(div_half);
  assign tick = run && (cnt == eff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mdio_c22_seq.sv
module mdio_c22_seq (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             tick,
  input  logic                             start,
  input  logic                             abort,
  input  logic                             wr,
  input  logic [mdio_c22_pkg::ADDR_W-1:0]  phy,
  input  logic [mdio_c22_pkg::ADDR_W-1:0]  rga,
  input  logic [mdio_c22_pkg::DATA_W-1:0]  wdata,
  input  logic                             line_in,
  output logic                             active,
  output logic                             clk_out,
  output logic                             drv_en,
  output logic                             drv_val,
  output logic                             done,
  output logic [mdio_c22_pkg::DATA_W-1:0]  rd_data,
  output logic                             ack_ok,
  output logic                             in_pre
);
  import mdio_c22_pkg::*;
  cyc_t              cyc;
  logic              wr_q, ack_n;
  logic [ADDR_W-1:0] phy_q, rga_q;
  logic [DATA_W-1:0] wd_q, shreg;
  logic [1:0]        drv;
  logic              rise_evt, fall_evt;

  assign rise_evt = active && tick && !clk_out;
  assign fall_evt = active && tick && clk_out;
  assign drv      = drive_slot(cyc, wr_q, phy_q, rga_q, wd_q);
  assign drv_en   = active && drv[1];
  assign drv_val  = active && drv[0];
  assign in_pre   = active && (cyc < HDR_FIRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; clk_out <= 1'b0; cyc <= '0; done <= 1'b0;
      wr_q <= 1'b0; phy_q <= '0; rga_q <= '0; wd_q <= '0;
      ack_n <= 1'b1; shreg <= '0; rd_data <= '0; ack_ok <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0; clk_out <= 1'b0; cyc <= '0;
      end else if (start) begin
        active <= 1'b1; clk_out <= 1'b0; cyc <= '0;
        wr_q <= wr; phy_q <= phy; rga_q <= rga; wd_q <= wdata;
        ack_n <= 1'b1;
      end else if (rise_evt) begin
        clk_out <= 1'b1;
        if (cyc == ACK_SLOT) ack_n <= line_in;
        if (cyc >= DATA_FIRST && cyc < LAST_SLOT)
          shreg <= {shreg[DATA_W-2:0], line_in};
      end else if (fall_evt) begin
        clk_out <= 1'b0;
        if (cyc == LAST_SLOT) begin
          active <= 1'b0;
          done   <= 1'b1;
          if (!wr_q) begin
            rd_data <= ack_n ? {DATA_W{1'b1}} : shreg;
            ack_ok  <= !ack_n;
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_c22_master.sv
module mdio_c22_master #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [4:0]       cmd_phy,
  input  logic [4:0]       cmd_reg,
  input  logic [15:0]      cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic [15:0]      rd_data,
  output logic             ack_ok,
  input  logic             man_en,
  input  logic [2:0]       man_ctrl,
  output logic             man_pin,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic seq_tick, seq_start, seq_mdc, seq_en, seq_val, seq_pre;

  assign seq_start = cmd_valid && !busy && !man_en;

  mdio_c22_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_half(div_half), .tick(seq_tick)
  );

  mdio_c22_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(seq_tick), .start(seq_start),
    .abort(man_en), .wr(cmd_write), .phy(cmd_phy), .rga(cmd_reg),
    .wdata(cmd_wdata), .line_in(mdio_i), .active(busy), .clk_out(seq_mdc),
    .drv_en(seq_en), .drv_val(seq_val), .done(done), .rd_data(rd_data),
    .ack_ok(ack_ok), .in_pre(seq_pre)
  );

  assign mdc     = man_en ? man_ctrl[2] : seq_mdc;
  assign mdio_oe = man_en ? man_ctrl[1] : seq_en;
  assign mdio_o  = man_en ? man_ctrl[0] : seq_val;

  always_ff @(posedge clk) begin
    if (!rst_n) man_pin <= 1'b0;
    else        man_pin <= mdio_i;
  end
endmodule

// File: rtl/mdio_c22_checker.sv
module mdio_c22_checker (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdio_oe,
  input logic man_en,
  input logic cmd_valid,
  input logic tick,
  input logic in_preamble
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !man_en) |-> (!mdc && !mdio_oe));
  a_r2_preamble_released: assert property (@(posedge clk) disable iff (!rst_n)
    (in_preamble && !man_en) |-> !mdio_oe);
  a_r8_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_oe);
  a_r9_mdc_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_en && !$past(man_en) && !$stable(mdc)) |-> $past(tick));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  a_r10_accept_when_asked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_valid) && !$past(man_en)));
  a_r12_manual_stops_seq: assert property (@(posedge clk) disable iff (!rst_n)
    man_en |=> !busy);
endmodule

bind mdio_c22_master mdio_c22_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
  .mdio_oe(mdio_oe), .man_en(man_en), .cmd_valid(cmd_valid),
  .tick(seq_tick), .in_preamble(seq_pre)
);

// File: tb/sim_mdio_c22_master.sv
module sim_mdio_c22_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] div_half = 16'd3;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic man_en = 1'b0;
  logic [2:0] man_ctrl = '0;
  logic busy, done, ack_ok, man_pin, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i;

  logic phy_drive = 1'b0, phy_bit = 1'b1, phy_present = 1'b1, phy_rd = 1'b0;
  logic [15:0] phy_data = '0;
  logic log_oe [0:79];
  logic log_val[0:79];
  int rises = 0;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_drive ? phy_bit : 1'b1);

  mdio_c22_master u0 (
    .clk(clk), .rst_n(rst_n), .div_half(div_half), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
    .ack_ok(ack_ok), .man_en(man_en), .man_ctrl(man_ctrl), .man_pin(man_pin),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (rises < 80) begin
      log_oe[rises]  = mdio_oe;
      log_val[rises] = mdio_o;
    end
    rises = rises + 1;
  end

  // PHY model: changes its output after the MDC falling edge
  always @(negedge mdc) begin
    phy_drive = 1'b0;
    if (phy_rd && phy_present) begin
      if (rises == 47) begin
        phy_drive = 1'b1; phy_bit = 1'b0;
      end else if (rises >= 48 && rises <= 63) begin
        phy_drive = 1'b1; phy_bit = phy_data[63-rises];
      end
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] wd);
    @(negedge clk);
    rises = 0; phy_drive = 1'b0; phy_rd = !wr;
    cmd_valid = 1'b1; cmd_write = wr; cmd_phy = p; cmd_reg = r; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic check_header(input string req, input logic wr, input logic [4:0] p,
                              input logic [4:0] r);
    logic [3:0] hdr;
    logic [13:0] exp_bits, got_bits, got_en;
    hdr = wr ? 4'b0101 : 4'b0110;
    exp_bits = {hdr, p, r};
    for (int k = 0; k < 14; k++) begin
      got_bits[13-k] = log_val[32+k];
      got_en[13-k]   = log_oe[32+k];
    end
    check({req, " header enable"}, {18'd0, got_en}, {18'd0, 14'h3FFF});
    check({req, " header bits"}, {18'd0, got_bits}, {18'd0, exp_bits});
  endtask

  task automatic check_preamble();
    logic [31:0] en;
    for (int k = 0; k < 32; k++) en[k] = log_oe[k];
    check("R2 preamble released", en, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", {31'd0, busy}, 0);
    check("R1 done after reset", {31'd0, done}, 0);
    check("R1 mdc/oe after reset", {30'd0, mdc, mdio_oe}, 0);
  endtask

  task automatic t_read_ack();
    bit seen;
    logic [17:0] ta_en;
    div_half = 16'd3; phy_present = 1'b1; phy_data = 16'hA5C3;
    issue(1'b0, 5'h13, 5'h0A, 16'h0000);
    wait_done(seen);
    check("R10 done seen on read", {31'd0, seen}, 1);
    check("R8 rising edges per read frame", rises, 65);
    check_preamble();
    check_header("R3 R4 read", 1'b0, 5'h13, 5'h0A);
    for (int k = 0; k < 18; k++) ta_en[k] = log_oe[46+k];
    check("R5 read released after address", {14'd0, ta_en}, 0);
    check("R5 read data", {16'd0, rd_data}, 32'h0000A5C3);
    check("R5 ack flag", {31'd0, ack_ok}, 1);
    check("R8 released in last cycle", {31'd0, log_oe[64]}, 0);
  endtask

  task automatic t_read_noack();
    bit seen;
    phy_present = 1'b0; phy_data = 16'h1234;
    issue(1'b0, 5'h02, 5'h11, 16'h0000);
    wait_done(seen);
    check("R6 done without ack", {31'd0, seen}, 1);
    check("R6 all-ones data", {16'd0, rd_data}, 32'h0000FFFF);
    check("R6 ack flag clear", {31'd0, ack_ok}, 0);
    check("R6 full frame length", rises, 65);
    phy_present = 1'b1;
  endtask

  task automatic t_write();
    bit seen;
    logic [15:0] got;
    logic [15:0] got_en;
    issue(1'b1, 5'h01, 5'h1E, 16'h3C96);
    wait_done(seen);
    check("R10 done seen on write", {31'd0, seen}, 1);
    check_preamble();
    check_header("R3 R4 write", 1'b1, 5'h01, 5'h1E);
    check("R7 turnaround 1,0 driven",
          {28'd0, log_oe[46], log_val[46], log_oe[47], log_val[47]}, 32'hE);
    for (int k = 0; k < 16; k++) begin
      got[15-k] = log_val[48+k]; got_en[15-k] = log_oe[48+k];
    end
    check("R7 data bits MSB first", {got_en, got}, {16'hFFFF, 16'h3C96});
    check("R8 write release and length", {log_oe[64], 31'(rises)}, 32'd65);
  endtask

  task automatic t_busy_done();
    bit seen;
    int width;
    issue(1'b0, 5'h1F, 5'h00, 16'h0000);
    check("R10 busy after accept", {31'd0, busy}, 1);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_phy = 5'h05; cmd_reg = 5'h05;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(seen);
    width = 0;
    while (done && width < 10) begin width++; @(negedge clk); end
    check("R10 done one clock wide", width, 1);
    check("R10 busy low after done", {31'd0, busy}, 0);
    check_header("R10 command while busy ignored", 1'b0, 5'h1F, 5'h00);
    repeat (50) @(negedge clk);
    check("R10 no late start", {31'd0, busy}, 0);
  endtask

  task automatic t_divider(input logic [15:0] d, input int exp_hi);
    bit seen;
    int hi;
    div_half = d;
    issue(1'b0, 5'h00, 5'h00, 16'h0000);
    hi = 0;
    for (int k = 0; k < 200 && !mdc; k++) @(negedge clk);
    while (mdc && hi < 100) begin hi++; @(negedge clk); end
    check($sformatf("R9 high phase for divisor %0d", d), hi, exp_hi);
    wait_done(seen);
    check("R9 frame completes", rises, 65);
    div_half = 16'd3;
  endtask

  task automatic t_manual();
    @(negedge clk);
    man_en = 1'b1; man_ctrl = 3'b111;
    @(negedge clk);
    check("R11 manual drives pins", {29'd0, mdc, mdio_oe, mdio_o}, 32'h7);
    man_ctrl = 3'b010;
    repeat (2) @(negedge clk);
    check("R11 pin readback low", {30'd0, mdio_oe, man_pin}, 32'h2);
    man_ctrl = 3'b000;
    repeat (2) @(negedge clk);
    check("R11 pin readback pulled high", {29'd0, mdc, mdio_oe, man_pin}, 32'h1);
    cmd_valid = 1'b1; cmd_write = 1'b0;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    check("R12 command ignored in manual", {31'd0, busy}, 0);
    man_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_abort();
    bit seen;
    int dones;
    issue(1'b0, 5'h0C, 5'h03, 16'h0000);
    repeat (50) @(negedge clk);
    man_en = 1'b1; man_ctrl = 3'b000;
    dones = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R12 abort clears busy", {31'd0, busy}, 0);
    check("R12 no done after abort", dones, 0);
    man_en = 1'b0;
    phy_data = 16'h0F0F;
    issue(1'b0, 5'h0C, 5'h03, 16'h0000);
    wait_done(seen);
    check("R12 recovery read", {15'd0, ack_ok, rd_data}, 32'h00010F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_read_ack();
    t_read_noack();
    t_write();
    t_busy_done();
    t_divider(16'd5, 5);
    t_divider(16'd0, 1);
    t_manual();
    t_abort();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule